// File: doc/BRIEF.md
# Debug-Mode Address Segment Classifier

This block sorts every processor memory access into a destination class. A core can be running normally or in a debug mode. The block decides whether an access goes to a fixed uncached debug window, to unmapped kernel space, or to translated space. It also decides whether the access is cacheable and whether it raises an exception.

The debug window covers 0xFF20_0000 to 0xFF3F_FFFF. It exists only while debug mode is active and the static configuration input `no_dseg_i` is low. Coprocessor loads and stores aimed at the window fault. A translation miss during debug mode gives a debug re-entry code instead of the ordinary TLB exception. Outside the window, debug-mode accesses follow the kernel map. The TLB lookup is done elsewhere, and its hit flag and cache attribute arrive with the request.

Each result is registered, and a response strobe follows the request strobe by one clock.

Top module: `dbg_seg_classifier`

## Requirements
- R1: `rsp_valid_o` is high exactly one clock after `req_valid_i` was high, and low otherwise. An active-low reset clears it.
- R2: In debug mode with `no_dseg_i`=0, an address from 0xFF20_0000 to 0xFF3F_FFFF gives target 2'b00 (debug window), non-cacheable and exception 2'b00 (none) for a fetch (kind 3'd0), load (3'd1) or store (3'd2).
- R3: A coprocessor load (kind 3'd3) or coprocessor store (kind 3'd4) that hits the debug window gives target 2'b00 and exception 2'b11 (debug address fault).
- R4: With `no_dseg_i`=1, debug-mode accesses in the window range are handled as mapped kernel accesses. A TLB hit gives target 2'b10 with the TLB cache attribute. A miss gives exception 2'b10.
- R5: 0x8000_0000 to 0x9FFF_FFFF gives target 2'b01 (unmapped), cacheable. 0xA000_0000 to 0xBFFF_FFFF gives target 2'b01, non-cacheable. Neither raises an exception.
- R6: An access to a mapped region (below 0x8000_0000, or from 0xC000_0000 up, outside an active window) that hits the TLB gives target 2'b10 and exception 2'b00. Its cacheable flag equals `tlb_cacheable_i`.
- R7: A mapped access in debug mode that misses the TLB gives exception 2'b10 (debug re-entry), never 2'b01, and is non-cacheable.
- R8: Outside debug mode the window range is ordinary mapped space. A TLB miss there, or at any mapped address, gives exception 2'b01 (TLB miss).
- R9: The TLB hit and cache attribute inputs have no effect on accesses to the debug window or to unmapped space.
- R10: Coprocessor accesses outside an active debug window are classified exactly like loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| vaddr_i | input | 32 | Virtual address |
| kind_i | input | 3 | Access kind: 0 fetch, 1 load, 2 store, 3 coprocessor load, 4 coprocessor store |
| dbg_mode_i | input | 1 | Core is in debug mode |
| no_dseg_i | input | 1 | Static: 1 removes the debug window |
| tlb_hit_i | input | 1 | TLB lookup hit |
| tlb_cacheable_i | input | 1 | TLB cache attribute for a hit |
| rsp_valid_o | output | 1 | Result strobe, one clock after request |
| target_o | output | 2 | 00 debug window, 01 unmapped kernel, 10 translated |
| cacheable_o | output | 1 | Access is cacheable |
| exc_o | output | 2 | 00 none, 01 TLB miss, 10 debug re-entry, 11 debug address fault |

## Verification
Every result appears on the outputs in the clock after the edge that captured the request. The inputs pass through one register stage. The bench drives each request on a falling edge and holds it for one rising edge. It samples all four outputs on the next falling edge, which is the first point where the captured result is visible. Between requests the bench also checks that the strobe drops in the following cycle, so the one-cycle spacing is confirmed in both directions.

// File: rtl/dbg_seg_pkg.sv
package dbg_seg_pkg;
  typedef enum logic [2:0] {
    ACC_FETCH     = 3'd0,
    ACC_LOAD      = 3'd1,
    ACC_STORE     = 3'd2,
    ACC_COP_LOAD  = 3'd3,
    ACC_COP_STORE = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    TGT_DSEG     = 2'b00,
    TGT_UNMAPPED = 2'b01,
    TGT_XLATE    = 2'b10
  } target_e;

  typedef enum logic [1:0] {
    EXC_NONE       = 2'b00,
    EXC_TLB_MISS   = 2'b01,
    EXC_DBG_REENT  = 2'b10,
    EXC_DBG_AFAULT = 2'b11
  } exc_e;

  typedef enum logic [1:0] {
    RGN_MAPPED       = 2'd0,
    RGN_UNM_CACHED   = 2'd1,
    RGN_UNM_UNCACHED = 2'd2
  } rgn_e;

  typedef struct packed {
    target_e  target;
    logic     cacheable;
    exc_e     exc;
  } cls_res_t;

  function automatic logic is_cop(input logic [2:0] kind);
    return (kind == ACC_COP_LOAD) || (kind == ACC_COP_STORE);
  endfunction
endpackage

// File: rtl/dbg_seg_region_dec.sv
module dbg_seg_region_dec
  import dbg_seg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] UNM_LO    = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] UNM_SPLIT = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] UNM_END   = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] DSEG_LO   = 32'hFF20_0000,
  parameter logic [ADDR_W-1:0] DSEG_HI   = 32'hFF3F_FFFF,
  parameter bit                HAS_DSEG  = 1'b1
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  output rgn_e              rgn_o,
  output logic              in_dseg_rng_o
);
  logic ge_lo, ge_split, ge_end;

  assign ge_lo    = (vaddr_i >= UNM_LO);
  assign ge_split = (vaddr_i >= UNM_SPLIT);
  assign ge_end   = (vaddr_i >= UNM_END);

  always_comb begin
    rgn_o = RGN_MAPPED;
    if (ge_lo && !ge_split)      rgn_o = RGN_UNM_CACHED;
    else if (ge_split && !ge_end) rgn_o = RGN_UNM_UNCACHED;
  end

  generate
    if (HAS_DSEG) begin : g_dseg
      assign in_dseg_rng_o = (vaddr_i >= DSEG_LO) && (vaddr_i <= DSEG_HI);
    end else begin : g_no_dseg
      assign in_dseg_rng_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dbg_seg_resolve.sv
module dbg_seg_resolve
  import dbg_seg_pkg::*;
(
  input  rgn_e        rgn_i,
  input  logic        in_dseg_rng_i,
  input  logic [2:0]  kind_i,
  input  logic        dbg_mode_i,
  input  logic        no_dseg_i,
  input  logic        tlb_hit_i,
  input  logic        tlb_cacheable_i,
  output cls_res_t    res_o
);
  logic dseg_live;

  assign dseg_live = dbg_mode_i && !no_dseg_i && in_dseg_rng_i;

  always_comb begin
    res_o = '{target: TGT_XLATE, cacheable: 1'b0, exc: EXC_NONE};
    if (dseg_live) begin
      res_o.target = TGT_DSEG;
      res_o.exc    = is_cop(kind_i) ? EXC_DBG_AFAULT : EXC_NONE;
    end else begin
      unique case (rgn_i)
        RGN_UNM_CACHED: begin
          res_o.target    = TGT_UNMAPPED;
          res_o.cacheable = 1'b1;
        end
        RGN_UNM_UNCACHED: begin
          res_o.target = TGT_UNMAPPED;
        end
        default: begin
          res_o.target = TGT_XLATE;
          if (tlb_hit_i) begin
            res_o.cacheable = tlb_cacheable_i;
          end else begin
            // translation faults in debug re-enter debug instead of the TLB handler
            res_o.exc = dbg_mode_i ? EXC_DBG_REENT : EXC_TLB_MISS;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbg_seg_out_reg.sv
module dbg_seg_out_reg
  import dbg_seg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  cls_res_t res_i,
  output logic     valid_o,
  output cls_res_t res_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '{target: TGT_DSEG, cacheable: 1'b0, exc: EXC_NONE};
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_i;
    end
  end
endmodule

// File: rtl/dbg_seg_classifier.sv
module dbg_seg_classifier
  import dbg_seg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] UNM_LO    = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] UNM_SPLIT = 32'hA000_0000,
  parameter logic [ADDR_W-1:0] UNM_END   = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] DSEG_LO   = 32'hFF20_0000,
  parameter logic [ADDR_W-1:0] DSEG_HI   = 32'hFF3F_FFFF,
  parameter bit                HAS_DSEG  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [2:0]        kind_i,
  input  logic              dbg_mode_i,
  input  logic              no_dseg_i,
  input  logic              tlb_hit_i,
  input  logic              tlb_cacheable_i,
  output logic              rsp_valid_o,
  output logic [1:0]        target_o,
  output logic              cacheable_o,
  output logic [1:0]        exc_o
);
  rgn_e     rgn;
  logic     in_rng;
  cls_res_t res_d, res_q;

  dbg_seg_region_dec #(
    .ADDR_W(ADDR_W), .UNM_LO(UNM_LO), .UNM_SPLIT(UNM_SPLIT), .UNM_END(UNM_END),
    .DSEG_LO(DSEG_LO), .DSEG_HI(DSEG_HI), .HAS_DSEG(HAS_DSEG)
  ) u_dec (
    .vaddr_i       (vaddr_i),
    .rgn_o         (rgn),
    .in_dseg_rng_o (in_rng)
  );

  dbg_seg_resolve u_res (
    .rgn_i           (rgn),
    .in_dseg_rng_i   (in_rng),
    .kind_i          (kind_i),
    .dbg_mode_i      (dbg_mode_i),
    .no_dseg_i       (no_dseg_i),
    .tlb_hit_i       (tlb_hit_i),
    .tlb_cacheable_i (tlb_cacheable_i),
    .res_o           (res_d)
  );

  dbg_seg_out_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .res_i   (res_d),
    .valid_o (rsp_valid_o),
    .res_o   (res_q)
  );

  assign target_o    = res_q.target;
  assign cacheable_o = res_q.cacheable;
  assign exc_o       = res_q.exc;
endmodule

// File: rtl/dbg_seg_classifier_chk.sv
module dbg_seg_classifier_chk #(
  parameter int unsigned       ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] DSEG_LO = 32'hFF20_0000,
  parameter logic [ADDR_W-1:0] DSEG_HI = 32'hFF3F_FFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] vaddr_i,
  input logic [2:0]        kind_i,
  input logic              dbg_mode_i,
  input logic              no_dseg_i,
  input logic              rsp_valid_o,
  input logic [1:0]        target_o,
  input logic              cacheable_o,
  input logic [1:0]        exc_o
);
  logic live_win, cop;
  assign live_win = dbg_mode_i && !no_dseg_i && (vaddr_i >= DSEG_LO) && (vaddr_i <= DSEG_HI);
  assign cop      = (kind_i == 3'd3) || (kind_i == 3'd4);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o) else $error("rsp strobe missing"); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o) else $error("spurious rsp"); // R1
  AST_WIN_UNCACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && target_o == 2'b00) |-> !cacheable_o) else $error("window cached"); // R2
  AST_COP_WIN_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && live_win && cop) |=> (exc_o == 2'b11 && target_o == 2'b00))
    else $error("cop window not faulted"); // R3
  AST_NO_WIN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && no_dseg_i) |=> (target_o != 2'b00)) else $error("window while removed"); // R4
  AST_DBG_CODES_IN_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dbg_mode_i) |=> !exc_o[1]) else $error("debug code outside debug"); // R8
  AST_MISS_IS_XLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (exc_o == 2'b01 || exc_o == 2'b10)) |-> target_o == 2'b10)
    else $error("miss on non-translated"); // R7
endmodule

bind dbg_seg_classifier dbg_seg_classifier_chk #(
  .ADDR_W(ADDR_W), .DSEG_LO(DSEG_LO), .DSEG_HI(DSEG_HI)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .vaddr_i(vaddr_i),
  .kind_i(kind_i), .dbg_mode_i(dbg_mode_i), .no_dseg_i(no_dseg_i),
  .rsp_valid_o(rsp_valid_o), .target_o(target_o), .cacheable_o(cacheable_o), .exc_o(exc_o)
);

// File: tb/dbg_seg_classifier_tb_top.sv
`timescale 1ns/1ps
module dbg_seg_classifier_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [2:0]  kind_i = '0;
  logic        dbg_mode_i = 1'b0;
  logic        no_dseg_i = 1'b0;
  logic        tlb_hit_i = 1'b0;
  logic        tlb_cacheable_i = 1'b0;
  logic        rsp_valid_o, cacheable_o;
  logic [1:0]  target_o, exc_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dbg_seg_classifier dut_i (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic [2:0] k,
                        input logic dbg, input logic nod, input logic hit, input logic tc,
                        input int e_tgt, input int e_c, input int e_exc);
    @(negedge clk_i);
    req_valid_i = 1'b1; vaddr_i = a; kind_i = k; dbg_mode_i = dbg;
    no_dseg_i = nod; tlb_hit_i = hit; tlb_cacheable_i = tc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req, "valid", int'(rsp_valid_o), 1);
    chk(req, "target", int'(target_o), e_tgt);
    chk(req, "cacheable", int'(cacheable_o), e_c);
    chk(req, "exc", int'(exc_o), e_exc);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R1", "reset valid", int'(rsp_valid_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_strobe();
    access("R1", 32'h8000_0000, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1, 0);
    @(negedge clk_i);
    chk("R1", "valid drop", int'(rsp_valid_o), 0);
  endtask

  task automatic t_window();
    access("R2", 32'hFF20_0000, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 0, 0, 0);
    access("R2", 32'hFF3F_FFFF, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 0, 0);
    access("R2", 32'hFF30_1234, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 0);
    // just outside the window: mapped kernel, hit
    access("R6", 32'hFF1F_FFFF, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1, 0);
    access("R6", 32'hFF40_0000, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2, 0, 0);
  endtask

  task automatic t_cop_window();
    access("R3", 32'hFF20_0040, 3'd3, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 3);
    access("R3", 32'hFF3F_FFFC, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 3);
  endtask

  task automatic t_no_window();
    access("R4", 32'hFF20_0000, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2, 1, 0);
    access("R4", 32'hFF28_0000, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2, 0, 2);
    access("R4", 32'hFF28_0000, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2, 0, 0);
  endtask

  task automatic t_unmapped();
    access("R5", 32'h8000_0000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1, 0);
    access("R5", 32'h9FFF_FFFF, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1, 0);
    access("R5", 32'hA000_0000, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0, 0);
    access("R5", 32'hBFFF_FFFF, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1, 0, 0);
    // R9: tlb inputs ignored in unmapped and window space
    access("R9", 32'h8123_0000, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1, 1, 0);
    access("R9", 32'hA123_0000, 3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1, 0, 0);
    access("R9", 32'hFF21_0000, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0, 0);
  endtask

  task automatic t_mapped_hit();
    access("R6", 32'h0000_1000, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1, 0);
    access("R6", 32'h7FFF_FFFF, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 2, 0, 0);
    access("R6", 32'hC000_0000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1, 0);
  endtask

  task automatic t_dbg_miss();
    access("R7", 32'h0040_0000, 3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2, 0, 2);
    access("R7", 32'hC000_0000, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2, 0, 2);
  endtask

  task automatic t_kernel_miss();
    access("R8", 32'hFF20_0000, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2, 0, 1);
    access("R8", 32'hFF30_0000, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1, 0);
    access("R8", 32'h1000_0000, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2, 0, 1);
  endtask

  task automatic t_cop_outside();
    access("R10", 32'h8000_1000, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1, 0);
    access("R10", 32'h0000_2000, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 2, 0, 2);
    access("R10", 32'hC100_0000, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_strobe();
    t_window();
    t_cop_window();
    t_no_window();
    t_unmapped();
    t_mapped_hit();
    t_dbg_miss();
    t_kernel_miss();
    t_cop_outside();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule